// File: doc/BRIEF.md
# Multi-Mode Priority Interrupt Resolver

The block collects up to eight interrupt requests from local peripherals and presents a single interrupt line to a local processor. Each cycle, a combinational priority network picks the most urgent pending, unmasked request. The request must also outrank every level the processor is already servicing. The processor answers the interrupt with an acknowledge pulse. The block then returns the winning level number and moves that level from the pending set to the in-service set.

Software drives a small register port. Through it, software selects one of three priority schemes, sets a mask, names the lowest-priority level and issues end-of-service commands. It can also read back the pending, mask and in-service sets.

- **Fixed nesting**: level 0 is the most urgent and level 7 the least.
- **Automatic rotation**: each level that finishes service drops to the bottom of the order.
- **Software-chosen bottom level**: the level that software writes is the least urgent, and the order wraps upward from it.

The acknowledge sequence is a three-state machine with these states and transitions:

- `ST_IDLE` moves to `ST_ASSERT` when an eligible request exists.
- `ST_ASSERT` moves to `ST_GRANT` on acknowledge, or back to `ST_IDLE` if the request loses eligibility first.
- `ST_GRANT` always returns to `ST_IDLE` after one cycle.

Top module: `irq_res_top`

## Requirements
- R1: After reset:
  - `int_req` and `ack_valid` are low.
  - The pending, mask and in-service sets read as zero.
  - The configuration readback (address 3) reads 0x07, which means fixed nesting with bottom level 7.
- R2: A pending bit sets at the clock edge where its `irq_in` line is high. It stays set until that level is acknowledged, even if the line falls. Address 0 reads the pending set, with bit i for level i.
- R3: For a lone unmasked request with nothing in service, `int_req` rises at the second clock edge after `irq_in` is first sampled high. That is one edge to set the pending bit (the machine is still in `ST_IDLE`) and one edge to enter `ST_ASSERT`.
- R4: When `inta` is sampled high while `int_req` is high:
  - The machine enters `ST_GRANT`.
  - `ack_valid` is high for exactly one cycle, and `ack_level` carries the winning level during that cycle.
  - At the same edge, the winner's in-service bit sets and its pending bit clears.
  - Address 2 reads the in-service set.
- R5: Mode code 0, written to address 0 bits [1:0], selects fixed nesting: the lower level number always wins. Code 3 behaves the same as code 0.
- R6: Mode code 1 selects rotation:
  - An end-of-service command makes the level it clears the least urgent.
  - The order then continues from the next higher number, wrapping at 7.
  - Address 3 reads mode in bits [4:3] and the bottom level in bits [2:0].
- R7: Mode code 2 selects the software bottom level. A write of L to address 2 makes L the least urgent, and the order is L+1, L+2, …, L, modulo 8.
- R8: A bit set in the mask register (address 1, bit i for level i) stops that level from raising `int_req` or winning. Its pending bit still sets and is still readable.
- R9: A pending request raises `int_req` only if it is strictly more urgent than the most urgent in-service level. A more urgent request does raise `int_req` while a less urgent level is in service.
- R10: Any write to address 3 is an end-of-service command. It clears only the most urgent in-service bit. In modes 0, 2 and 3 the bottom level is left unchanged.
- R11: If the request in `ST_ASSERT` loses eligibility before acknowledge (for example, it is masked), the machine returns to `ST_IDLE` and `int_req` falls one edge after the mask takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines, high = requesting |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (write and read) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| int_req | output | 1 | Interrupt request to processor |
| inta | input | 1 | Acknowledge from processor |
| ack_valid | output | 1 | One-cycle strobe: `ack_level` is valid |
| ack_level | output | 3 | Level granted by the acknowledge |

## Verification
The results arrive on a fixed schedule:

- A pending bit is readable one edge after its line rises.
- `int_req` follows one edge later, so it is due at the second edge.
- `ack_valid` and `ack_level` are due one edge after `inta` is sampled.
- Register writes and end-of-service commands are visible in readback one edge after the strobe.

The bench drives inputs and samples outputs on falling edges, so each check lands in a cycle where the count of registers from stimulus to output is settled. The priority sweeps cover every ordered pair of levels in fixed nesting, every bottom level with all eight levels pending, and a full rotation cycle. Each expected winner is computed with modular arithmetic on the level numbers.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    typedef enum logic [1:0] {
        MODE_NESTED   = 2'd0,
        MODE_ROTATE   = 2'd1,
        MODE_SPECIFIC = 2'd2,
        MODE_ALIAS    = 2'd3
    } prio_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ASSERT = 2'd1,
        ST_GRANT  = 2'd2
    } ack_state_e;

    localparam logic [1:0] ADDR_MODE_IRR = 2'd0;
    localparam logic [1:0] ADDR_MASK     = 2'd1;
    localparam logic [1:0] ADDR_LOW_ISR  = 2'd2;
    localparam logic [1:0] ADDR_EOI_CFG  = 2'd3;

endpackage

// File: rtl/irq_rank_pick.sv
module irq_rank_pick #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] vec,
    input  logic [W-1:0] low,
    output logic         hit,
    output logic [W-1:0] idx,
    output logic [W-1:0] rank
);

    // Rank k = 0 is the level just above the bottom level; rank N-1 is the bottom.
    // Scanning from the least urgent rank down leaves the most urgent hit standing.
    always_comb begin
        logic [W-1:0] pos;
        hit  = 1'b0;
        idx  = '0;
        rank = '0;
        pos  = '0;
        for (int k = N - 1; k >= 0; k--) begin
            pos = low + W'(1) + W'(k);
            if (vec[pos]) begin
                hit  = 1'b1;
                idx  = pos;
                rank = W'(k);
            end
        end
    end

endmodule

// File: rtl/irq_res_regs.sv
module irq_res_regs
    import irq_res_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic         reg_wr,
    input  logic [1:0]   reg_addr,
    input  logic [N-1:0] reg_wdata,
    input  logic         grant_fire,
    input  logic [W-1:0] grant_idx,
    input  logic         isr_hit,
    input  logic [W-1:0] isr_top,
    output logic [N-1:0] irr_q,
    output logic [N-1:0] imr_q,
    output logic [N-1:0] isr_q,
    output logic [W-1:0] eff_low,
    output logic [N-1:0] reg_rdata
);

    localparam int CFG_W = 2 + W;

    prio_mode_e   mode_q;
    logic [W-1:0] low_q;
    logic         eoi_fire;
    logic [N-1:0] grant_vec;
    logic [N-1:0] eoi_vec;

    assign eoi_fire  = reg_wr && (reg_addr == ADDR_EOI_CFG);
    assign grant_vec = grant_fire ? (N'(1) << grant_idx) : '0;
    assign eoi_vec   = (eoi_fire && isr_hit) ? (N'(1) << isr_top) : '0;

    always_comb begin
        unique case (mode_q)
            MODE_ROTATE, MODE_SPECIFIC: eff_low = low_q;
            default:                    eff_low = W'(N - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q  <= '0;
            imr_q  <= '0;
            isr_q  <= '0;
            mode_q <= MODE_NESTED;
            low_q  <= W'(N - 1);
        end else begin
            irr_q <= (irr_q | irq_in) & ~grant_vec;
            isr_q <= (isr_q & ~eoi_vec) | grant_vec;
            if (reg_wr) begin
                unique case (reg_addr)
                    ADDR_MODE_IRR: mode_q <= prio_mode_e'(reg_wdata[1:0]);
                    ADDR_MASK:     imr_q  <= reg_wdata;
                    ADDR_LOW_ISR:  low_q  <= reg_wdata[W-1:0];
                    ADDR_EOI_CFG: begin
                        if (isr_hit && mode_q == MODE_ROTATE) begin
                            low_q <= isr_top;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_MODE_IRR: reg_rdata = irr_q;
            ADDR_MASK:     reg_rdata = imr_q;
            ADDR_LOW_ISR:  reg_rdata = isr_q;
            default:       reg_rdata = N'({mode_q, low_q});
        endcase
    end

    // R4
    grant_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_fire |=> isr_q[$past(grant_idx)]);

    // R4
    grant_clears_irr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_fire |=> !irr_q[$past(grant_idx)]);

    // R10
    eoi_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_fire && isr_hit && !grant_fire) |=>
            ($countones(isr_q) == $countones($past(isr_q)) - 1));

    // R6
    rotate_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_fire && isr_hit && mode_q == MODE_ROTATE) |=> (low_q == $past(isr_top)));

    // R2
    pending_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irr_q[0] && !(grant_fire && grant_idx == '0)) |=> irr_q[0]);

endmodule

// File: rtl/irq_res_fsm.sv
module irq_res_fsm
    import irq_res_pkg::*;
#(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         want,
    input  logic         inta,
    input  logic [W-1:0] win_idx,
    output logic         int_req,
    output logic         ack_valid,
    output logic [W-1:0] ack_level,
    output logic         grant_fire,
    output logic [W-1:0] grant_idx
);

    ack_state_e   state_q;
    ack_state_e   state_n;
    logic [W-1:0] level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            level_q <= '0;
        end else begin
            state_q <= state_n;
            if (grant_fire) begin
                level_q <= win_idx;
            end
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (want) state_n = ST_ASSERT;
            end
            ST_ASSERT: begin
                if (inta && want) state_n = ST_GRANT;
                else if (!want)   state_n = ST_IDLE;
            end
            ST_GRANT: state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        int_req    = (state_q == ST_ASSERT);
        ack_valid  = (state_q == ST_GRANT);
        ack_level  = level_q;
        grant_fire = (state_q == ST_ASSERT) && inta && want;
        grant_idx  = win_idx;
    end

    // R3
    idle_to_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && want) |=> int_req);

    // R4
    inta_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && inta && want) |=> (ack_valid && ack_level == $past(win_idx)));

    // R4
    ack_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid);

    // R11
    lost_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && !want) |=> !int_req);

endmodule

// File: rtl/irq_res_top.sv
module irq_res_top
    import irq_res_pkg::*;
#(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic         reg_wr,
    input  logic [1:0]   reg_addr,
    input  logic [N-1:0] reg_wdata,
    output logic [N-1:0] reg_rdata,
    output logic         int_req,
    input  logic         inta,
    output logic         ack_valid,
    output logic [W-1:0] ack_level
);

    logic [N-1:0] irr_q;
    logic [N-1:0] imr_q;
    logic [N-1:0] isr_q;
    logic [N-1:0] cand;
    logic [W-1:0] eff_low;
    logic         req_hit;
    logic [W-1:0] req_idx;
    logic [W-1:0] req_rank;
    logic         isr_hit;
    logic [W-1:0] isr_top;
    logic [W-1:0] isr_rank;
    logic         want;
    logic         grant_fire;
    logic [W-1:0] grant_idx;

    assign cand = irr_q & ~imr_q;

    irq_rank_pick #(.N(N), .W(W)) u_req_pick (
        .vec  (cand),
        .low  (eff_low),
        .hit  (req_hit),
        .idx  (req_idx),
        .rank (req_rank)
    );

    irq_rank_pick #(.N(N), .W(W)) u_isr_pick (
        .vec  (isr_q),
        .low  (eff_low),
        .hit  (isr_hit),
        .idx  (isr_top),
        .rank (isr_rank)
    );

    assign want = req_hit && (!isr_hit || (req_rank < isr_rank));

    irq_res_regs #(.N(N), .W(W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .grant_fire (grant_fire),
        .grant_idx  (grant_idx),
        .isr_hit    (isr_hit),
        .isr_top    (isr_top),
        .irr_q      (irr_q),
        .imr_q      (imr_q),
        .isr_q      (isr_q),
        .eff_low    (eff_low),
        .reg_rdata  (reg_rdata)
    );

    irq_res_fsm #(.W(W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .want       (want),
        .inta       (inta),
        .win_idx    (req_idx),
        .int_req    (int_req),
        .ack_valid  (ack_valid),
        .ack_level  (ack_level),
        .grant_fire (grant_fire),
        .grant_idx  (grant_idx)
    );

    // R8
    masked_never_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_fire |-> !imr_q[grant_idx]);

    // R9
    grant_outranks_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_fire |-> !(isr_hit && isr_rank <= req_rank));

endmodule

// File: tb/irq_res_top_tb.sv
module irq_res_top_tb;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] irq_in;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       int_req;
    logic       inta;
    logic       ack_valid;
    logic [2:0] ack_level;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    irq_res_top #(.N(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .int_req   (int_req),
        .inta      (inta),
        .ack_valid (ack_valid),
        .ack_level (ack_level)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic eoi();
        wr_reg(2'd3, 8'h00);
    endtask

    task automatic ack_expect(input string tag, input int exp);
        int waited = 0;
        while (!int_req && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        if (!int_req) begin
            chk({tag, " int_req"}, 0, 1);
        end else begin
            inta = 1'b1;
            @(negedge clk);
            inta = 1'b0;
            chk({tag, " ack_valid"}, int'(ack_valid), 1);
            chk({tag, " ack_level"}, int'(ack_level), exp);
            irq_in[exp[2:0]] = 1'b0;
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int v;
        rst_n = 1'b0; irq_in = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; inta = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 int_req", int'(int_req), 0);
        chk("R1 ack_valid", int'(ack_valid), 0);
        rd_reg(2'd0, v); chk("R1 pending", v, 0);
        rd_reg(2'd1, v); chk("R1 mask", v, 0);
        rd_reg(2'd2, v); chk("R1 in-service", v, 0);
        rd_reg(2'd3, v); chk("R1 config", v, 8'h07);

        // R3 latency from line to int_req; R2 pending bit visible after one edge
        @(negedge clk);
        irq_in[2] = 1'b1;
        @(negedge clk);
        chk("R3 int_req after 1 edge", int'(int_req), 0);
        rd_reg(2'd0, v); chk("R2 pending set", v, 8'h04);
        @(negedge clk);
        chk("R3 int_req after 2 edges", int'(int_req), 1);
        irq_in[2] = 1'b0;
        @(negedge clk);
        rd_reg(2'd0, v); chk("R2 pending sticky", v, 8'h04);
        ack_expect("R4", 2);
        rd_reg(2'd2, v); chk("R4 in-service set", v, 8'h04);
        rd_reg(2'd0, v); chk("R4 pending cleared", v, 0);
        @(negedge clk);
        chk("R4 ack_valid one cycle", int'(ack_valid), 0);
        eoi();
        rd_reg(2'd2, v); chk("R10 in-service cleared", v, 0);

        // R5 every ordered pair in fixed nesting
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                if (a != b) begin
                    @(negedge clk);
                    irq_in = 8'((1 << a) | (1 << b));
                    ack_expect("R5 first", (a < b) ? a : b);
                    eoi();
                    ack_expect("R5 second", (a < b) ? b : a);
                    eoi();
                end
            end
        end

        // R7 every bottom level with all levels pending
        wr_reg(2'd0, 8'd2);
        for (int L = 0; L < N; L++) begin
            wr_reg(2'd2, 8'(L));
            @(negedge clk);
            irq_in = 8'hFF;
            for (int k = 0; k < N; k++) begin
                ack_expect("R7", (L + 1 + k) % N);
                eoi();
            end
        end
        rd_reg(2'd3, v); chk("R10 bottom kept in mode 2", v, (2 << 3) | 7);

        // R6 rotation
        wr_reg(2'd0, 8'd1);
        wr_reg(2'd2, 8'd7);
        @(negedge clk);
        irq_in = 8'hFF;
        for (int k = 0; k < N; k++) begin
            ack_expect("R6 full round", k);
            eoi();
        end
        rd_reg(2'd3, v); chk("R6 bottom after round", v, (1 << 3) | 7);
        @(negedge clk);
        irq_in = 8'h44;
        ack_expect("R6 pair a", 2);
        eoi();
        rd_reg(2'd3, v); chk("R6 bottom moved", v, (1 << 3) | 2);
        irq_in[2] = 1'b1;
        ack_expect("R6 pair b", 6);
        eoi();
        ack_expect("R6 pair c", 2);
        eoi();

        // R8 masking, R9 nesting, R10 partial end-of-service
        wr_reg(2'd0, 8'd3);
        wr_reg(2'd1, 8'h01);
        irq_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 masked no int_req", int'(int_req), 0);
        rd_reg(2'd0, v); chk("R8 masked still pending", v, 8'h01);
        irq_in[4] = 1'b1;
        ack_expect("R8 unmasked wins", 4);
        wr_reg(2'd1, 8'h00);
        ack_expect("R9 higher nests", 0);
        rd_reg(2'd2, v); chk("R9 two in service", v, 8'h11);
        eoi();
        rd_reg(2'd2, v); chk("R10 clears most urgent", v, 8'h10);
        eoi();
        rd_reg(2'd2, v); chk("R10 clears last", v, 0);
        rd_reg(2'd3, v); chk("R10 bottom kept in mode 3", v, (3 << 3) | 2);

        // R9 lower request blocked while higher in service
        @(negedge clk);
        irq_in[3] = 1'b1;
        ack_expect("R9 first", 3);
        irq_in[5] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 blocked", int'(int_req), 0);
        eoi();
        ack_expect("R9 after service", 5);
        eoi();

        // R11 request loses eligibility in ST_ASSERT
        @(negedge clk);
        irq_in[6] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 asserted", int'(int_req), 1);
        wr_reg(2'd1, 8'h40);
        @(negedge clk);
        chk("R11 dropped", int'(int_req), 0);
        wr_reg(2'd1, 8'h00);
        ack_expect("R11 after unmask", 6);
        eoi();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule